// File: doc/BRIEF.md
# Multi-Stream Event Ring Buffer

This block collects event data arriving on several independent narrow input lanes and turns it into dense wide memory lines. Each lane may deliver a word in any cycle or stay idle. Idle cycles are simply skipped. Words are gathered into a line, and the line is closed when it is full or when the lane flags the last word of an event. Closed lines from all lanes compete for a single memory write port. A rotating arbiter serves them, one line per clock.

The shared memory is split into equal circular regions, one per lane. Each region keeps three pointers:
- a running write position, which advances with every line written;
- a committed position, which marks where the event now being built started;
- a read position, used by the readout side.

A trigger decision then either accepts the event, which moves the committed position up to the running one, or discards it, which rewinds the running position and drops any words not yet stored. Free space is derived from the running and read positions. A line that finds no room is dropped and leaves a sticky overflow flag for its lane. A lane that closes a second line before its previous one was granted also loses that line and gets the same flag.

The readout side selects a lane, gets the memory address of that lane's oldest committed line, and pulses a request to consume it.

Top module: `evbuf_top`

## Requirements
- R1: While reset is held and in the first cycle after it, no memory write is issued, every overflow and available flag is 0, and every lane reports free space of region size minus one (15 with defaults).
- R2: Valid words are placed into a line in arrival order, word k of a line in bits [16k+15:16k]; idle cycles between valid words leave no trace, and a line is written after 8 valid words.
- R3: A valid word flagged as end of event is stored and closes the line at once; the unused upper words of that line are zero.
- R4: A written line goes to address lane*16 + running pointer (lane in the upper address bits); the running pointer advances by one per written line and wraps from 15 to 0.
- R5: Free space of a lane is read minus running minus one when running is below read, and otherwise region size minus (running minus read) minus one.
- R6: An accept pulse copies the running pointer, including a write made in that same cycle, into the committed pointer; a lane's available flag is 1 exactly while its committed and read pointers differ.
- R7: A discard pulse sets the running pointer back to the committed pointer and drops the partial line, the waiting line and any word presented in the same cycle; discard wins over a simultaneous accept.
- R8: A granted line for a lane with zero free space is not written, and sets that lane's overflow flag, which stays set until reset; other lanes are unaffected.
- R9: Waiting lines are granted one per clock in rotating lane order; after reset lane 0 has first priority, and the write appears on the memory port one clock after the line is closed.
- R10: The read address is selected lane*16 + that lane's read pointer; a read request on a lane whose available flag is 1 advances its read pointer by one, wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | 192 | Input words, lane i in bits [16i+15:16i] |
| inValid | input | 12 | Per-lane word valid |
| inEnd | input | 12 | Per-lane end-of-event flag, qualifies the valid word |
| acceptCmd | input | 12 | Per-lane accept pulse |
| discardCmd | input | 12 | Per-lane discard pulse |
| rdReq | input | 1 | Consume one line of the selected lane |
| rdSel | input | 4 | Lane selected for readout |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 8 | Memory write line address |
| memData | output | 128 | Memory write line |
| freeLines | output | 48 | Free lines per lane, lane i in bits [4i+3:4i] |
| overflow | output | 12 | Sticky per-lane overflow flags |
| rdAvail | output | 12 | Per-lane committed data available |
| rdAddr | output | 8 | Memory address of the selected lane's oldest committed line |

## Verification
The hardest case to reach from the ports is a region that is completely full, with the running pointer wrapped just below a read pointer that is not zero. Only then can a dropped line and the overflow flag be seen. To get there, the stimulus first commits and drains one line on every lane, which leaves the read pointers at 1. It then sends fifteen single-word events into one lane, spaced so that each is written before the next arrives. This wraps the running pointer to 0 and brings free space to zero. A sixteenth event must then produce no write and a raised flag. A second hard spot is a discard in the same cycle as a valid word in the middle of a partial line: the next event's line must hold only its own word and land at the rewound address.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  // Lane index field width; supports up to 16 lanes.
  localparam int IDX_W = 4;

  // Strobes from control to datapath: which lane's waiting line is taken this cycle.
  typedef struct packed {
    logic             grantVld;
    logic [IDX_W-1:0] grantIdx;
  } evbufStrobe_t;
endpackage

// File: rtl/evbuf_lane.sv
module evbuf_lane #(
  parameter int SW = 16,
  parameter int LW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] word,
  input  logic          valid,
  input  logic          last,
  input  logic          drop,
  input  logic          take,
  output logic          pend,
  output logic          lost,
  output logic [LW-1:0] line
);
  localparam int WPL = LW / SW;
  localparam int CW  = $clog2(WPL);

  logic [LW-1:0] asmLine;
  logic [LW-1:0] merged;
  logic [CW-1:0] asmCnt;
  logic          closeLine;
  logic          slotBusy;

  // Current line with the incoming word dropped into its slot.
  always_comb begin
    merged = asmLine;
    merged[asmCnt*SW +: SW] = word;
  end

  assign closeLine = valid && (last || asmCnt == CW'(WPL - 1));
  // The waiting slot frees up in the same cycle it is granted.
  assign slotBusy  = pend && !take;
  assign lost      = !drop && closeLine && slotBusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      asmLine <= '0;
      asmCnt  <= '0;
      pend    <= 1'b0;
      line    <= '0;
    end else if (drop) begin
      asmLine <= '0;
      asmCnt  <= '0;
      pend    <= 1'b0;
    end else begin
      if (take) pend <= 1'b0;
      if (valid) begin
        if (closeLine) begin
          asmLine <= '0;
          asmCnt  <= '0;
          if (!slotBusy) begin
            line <= merged;
            pend <= 1'b1;
          end
        end else begin
          asmLine <= merged;
          asmCnt  <= asmCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evbuf_dp.sv
module evbuf_dp
  import evbuf_pkg::*;
#(
  parameter int NS = 12,
  parameter int SW = 16,
  parameter int LW = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS*SW-1:0] inData,
  input  logic [NS-1:0]    inValid,
  input  logic [NS-1:0]    inEnd,
  input  logic [NS-1:0]    discardCmd,
  input  evbufStrobe_t     strobe,
  output logic [NS-1:0]    pendMask,
  output logic [NS-1:0]    lostMask,
  output logic [LW-1:0]    memData
);
  logic [LW-1:0] laneLine [NS];

  for (genvar g = 0; g < NS; g++) begin : gLane
    evbuf_lane #(.SW(SW), .LW(LW)) uLane (
      .clk   (clk),
      .rst   (rst),
      .word  (inData[g*SW +: SW]),
      .valid (inValid[g]),
      .last  (inEnd[g]),
      .drop  (discardCmd[g]),
      .take  (strobe.grantVld && strobe.grantIdx == IDX_W'(g)),
      .pend  (pendMask[g]),
      .lost  (lostMask[g]),
      .line  (laneLine[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memData <= '0;
    end else if (strobe.grantVld) begin
      memData <= laneLine[strobe.grantIdx];
    end
  end
endmodule

// File: rtl/evbuf_rr.sv
module evbuf_rr
  import evbuf_pkg::*;
#(
  parameter int NS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    req,
  output logic             grantVld,
  output logic [IDX_W-1:0] grantIdx
);
  logic [IDX_W-1:0] lastIdx;
  int cand;

  // Search starts one past the last winner.
  always_comb begin
    grantVld = 1'b0;
    grantIdx = lastIdx;
    cand     = 0;
    for (int k = 1; k <= NS; k++) begin
      cand = (int'(lastIdx) + k) % NS;
      if (!grantVld && req[cand]) begin
        grantVld = 1'b1;
        grantIdx = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastIdx <= IDX_W'(NS - 1);
    end else if (grantVld) begin
      lastIdx <= grantIdx;
    end
  end
endmodule

// File: rtl/evbuf_ctl.sv
module evbuf_ctl
  import evbuf_pkg::*;
#(
  parameter int NS = 12,
  parameter int RL = 4,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    pendMask,
  input  logic [NS-1:0]    lostMask,
  input  logic [NS-1:0]    acceptCmd,
  input  logic [NS-1:0]    discardCmd,
  input  logic             rdReq,
  input  logic [IW-1:0]    rdSel,
  output evbufStrobe_t     strobe,
  output logic             memWe,
  output logic [IW+RL-1:0] memAddr,
  output logic [NS*RL-1:0] freeLines,
  output logic [NS-1:0]    overflow,
  output logic [NS-1:0]    rdAvail,
  output logic [IW+RL-1:0] rdAddr
);
  localparam int SIZE = 1 << RL;

  logic [RL-1:0]    runPtr  [NS];
  logic [RL-1:0]    comPtr  [NS];
  logic [RL-1:0]    rdPtr   [NS];
  logic [RL-1:0]    freeCnt [NS];
  logic [RL-1:0]    runNext [NS];
  logic [NS-1:0]    grantHit;
  logic [NS-1:0]    writeHit;
  logic             grantVld;
  logic [IDX_W-1:0] grantIdx;

  evbuf_rr #(.NS(NS)) uRr (
    .clk      (clk),
    .rst      (rst),
    .req      (pendMask & ~discardCmd),
    .grantVld (grantVld),
    .grantIdx (grantIdx)
  );

  assign strobe.grantVld = grantVld;
  assign strobe.grantIdx = grantIdx;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      if (runPtr[i] < rdPtr[i])
        freeCnt[i] = RL'(int'(rdPtr[i]) - int'(runPtr[i]) - 1);
      else
        freeCnt[i] = RL'((SIZE - 1) - (int'(runPtr[i]) - int'(rdPtr[i])));
      grantHit[i]             = grantVld && grantIdx == IDX_W'(i);
      writeHit[i]             = grantHit[i] && freeCnt[i] != '0;
      runNext[i]              = writeHit[i] ? runPtr[i] + 1'b1 : runPtr[i];
      freeLines[i*RL +: RL]   = freeCnt[i];
      rdAvail[i]              = comPtr[i] != rdPtr[i];
    end
  end

  assign rdAddr = {rdSel, rdPtr[rdSel]};

  always_ff @(posedge clk) begin
    if (rst) begin
      memWe    <= 1'b0;
      memAddr  <= '0;
      overflow <= '0;
      for (int i = 0; i < NS; i++) begin
        runPtr[i] <= '0;
        comPtr[i] <= '0;
        rdPtr[i]  <= '0;
      end
    end else begin
      memWe   <= |writeHit;
      memAddr <= {grantIdx[IW-1:0], runPtr[grantIdx]};
      for (int i = 0; i < NS; i++) begin
        if (discardCmd[i]) begin
          runPtr[i] <= comPtr[i];
        end else begin
          runPtr[i] <= runNext[i];
          if (acceptCmd[i]) comPtr[i] <= runNext[i];
        end
        overflow[i] <= overflow[i] | lostMask[i] | (grantHit[i] && freeCnt[i] == '0);
        if (rdReq && rdSel == IW'(i) && rdAvail[i]) rdPtr[i] <= rdPtr[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evbuf_top.sv
module evbuf_top
  import evbuf_pkg::*;
#(
  parameter  int NUM_STREAMS = 12,
  parameter  int WORD_W      = 16,
  parameter  int LINE_W      = 128,
  parameter  int REGION_LOG2 = 4,
  localparam int IDX_BITS    = $clog2(NUM_STREAMS),
  localparam int ADDR_W      = IDX_BITS + REGION_LOG2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_STREAMS*WORD_W-1:0]   inData,
  input  logic [NUM_STREAMS-1:0]          inValid,
  input  logic [NUM_STREAMS-1:0]          inEnd,
  input  logic [NUM_STREAMS-1:0]          acceptCmd,
  input  logic [NUM_STREAMS-1:0]          discardCmd,
  input  logic                            rdReq,
  input  logic [IDX_BITS-1:0]             rdSel,
  output logic                            memWe,
  output logic [ADDR_W-1:0]               memAddr,
  output logic [LINE_W-1:0]               memData,
  output logic [NUM_STREAMS*REGION_LOG2-1:0] freeLines,
  output logic [NUM_STREAMS-1:0]          overflow,
  output logic [NUM_STREAMS-1:0]          rdAvail,
  output logic [ADDR_W-1:0]               rdAddr
);
  evbufStrobe_t           strobe;
  logic [NUM_STREAMS-1:0] pendMask;
  logic [NUM_STREAMS-1:0] lostMask;

  evbuf_dp #(.NS(NUM_STREAMS), .SW(WORD_W), .LW(LINE_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .inData     (inData),
    .inValid    (inValid),
    .inEnd      (inEnd),
    .discardCmd (discardCmd),
    .strobe     (strobe),
    .pendMask   (pendMask),
    .lostMask   (lostMask),
    .memData    (memData)
  );

  evbuf_ctl #(.NS(NUM_STREAMS), .RL(REGION_LOG2), .IW(IDX_BITS)) uCtl (
    .clk        (clk),
    .rst        (rst),
    .pendMask   (pendMask),
    .lostMask   (lostMask),
    .acceptCmd  (acceptCmd),
    .discardCmd (discardCmd),
    .rdReq      (rdReq),
    .rdSel      (rdSel),
    .strobe     (strobe),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .freeLines  (freeLines),
    .overflow   (overflow),
    .rdAvail    (rdAvail),
    .rdAddr     (rdAddr)
  );
endmodule

// File: rtl/evbuf_chk.sv
module evbuf_chk #(
  parameter int NS = 12,
  parameter int RL = 4,
  parameter int IW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             memWe,
  input logic [IW+RL-1:0] memAddr,
  input logic [NS*RL-1:0] freeLines,
  input logic [NS-1:0]    overflow,
  input logic [NS-1:0]    rdAvail
);
  logic [NS*RL-1:0] prevFree;
  logic [RL-1:0]    selFree;
  logic [IW-1:0]    wrRegion;
  logic [RL-1:0]    wrOffset;

  always_ff @(posedge clk) begin
    if (rst) prevFree <= '0;
    else     prevFree <= freeLines;
  end

  assign wrRegion = memAddr[IW+RL-1:RL];
  assign wrOffset = memAddr[RL-1:0];
  assign selFree  = prevFree[int'(wrRegion)*RL +: RL];

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!memWe && overflow == '0 && rdAvail == '0)); // R1

  AST_REGION_RANGE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> int'(wrRegion) < NS); // R4

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (memWe && $past(memWe) && wrRegion == $past(wrRegion)) |-> wrOffset == RL'($past(wrOffset) + 1'b1)); // R4

  AST_ROOM_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> selFree != '0); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overflow != '0) |=> ((overflow & $past(overflow)) == $past(overflow))); // R8
endmodule

bind evbuf_top evbuf_chk #(.NS(NUM_STREAMS), .RL(REGION_LOG2), .IW(IDX_BITS)) uChk (
  .clk       (clk),
  .rst       (rst),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .freeLines (freeLines),
  .overflow  (overflow),
  .rdAvail   (rdAvail)
);

// File: tb/sim_evbuf_top.sv
module sim_evbuf_top;
  localparam int NS = 12, SW = 16, LW = 128, RL = 4, SIZE = 16, IW = 4, AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NS*SW-1:0] inData;
  logic [NS-1:0]    inValid, inEnd, acceptCmd, discardCmd;
  logic             rdReq;
  logic [IW-1:0]    rdSel;
  logic             memWe;
  logic [AW-1:0]    memAddr;
  logic [LW-1:0]    memData;
  logic [NS*RL-1:0] freeLines;
  logic [NS-1:0]    overflow, rdAvail;
  logic [AW-1:0]    rdAddr;

  evbuf_top u0 (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inEnd(inEnd),
    .acceptCmd(acceptCmd), .discardCmd(discardCmd), .rdReq(rdReq), .rdSel(rdSel),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .freeLines(freeLines),
    .overflow(overflow), .rdAvail(rdAvail), .rdAddr(rdAddr)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [LW-1:0] expQ [NS][$];
  logic [LW-1:0] asmL [NS];
  logic [LW-1:0] lastLine [NS];
  int asmN [NS], mdlRun [NS], mdlCom [NS], mdlRd [NS];
  int wrOrder [$], wrCyc [$];

  function automatic void check(bit ok, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic int mdlFree(int s);
    return ((mdlRd[s] - mdlRun[s] - 1) % SIZE + SIZE) % SIZE;
  endfunction

  function automatic void mdlPush(int s, logic [15:0] w, bit last, bit doQ);
    asmL[s][asmN[s]*SW +: SW] = w;
    asmN[s]++;
    if (last || asmN[s] == 8) begin
      if (doQ) expQ[s].push_back(asmL[s]);
      asmL[s] = '0;
      asmN[s] = 0;
    end
  endfunction

  always @(posedge clk) cyc++;

  // Per-clock comparison against the behavioural model.
  always @(negedge clk) begin
    int s, off;
    if (!rst) begin
      if (memWe) begin
        s   = int'(memAddr[AW-1:RL]);
        off = int'(memAddr[RL-1:0]);
        wrOrder.push_back(s);
        wrCyc.push_back(cyc);
        if (s >= NS || expQ[s].size() == 0) begin
          check(0, "R4 unexpected write address", memAddr, 0);
        end else begin
          check(off == mdlRun[s], "R4 write offset", off, mdlRun[s]);
          check(memData == expQ[s][0], "R2 line content", memData, expQ[s][0]);
          lastLine[s] = memData;
          void'(expQ[s].pop_front());
          mdlRun[s] = (mdlRun[s] + 1) % SIZE;
        end
      end
      for (int k = 0; k < NS; k++) begin
        check(int'(freeLines[k*RL +: RL]) == mdlFree(k), "R5 free space",
              freeLines[k*RL +: RL], mdlFree(k));
        check(rdAvail[k] == (mdlCom[k] != mdlRd[k]), "R6 available flag",
              rdAvail[k], (mdlCom[k] != mdlRd[k]));
      end
    end
  end

  task automatic put(int s, logic [15:0] w, bit last, bit doQ = 1);
    inData[s*SW +: SW] = w;
    inValid[s] = 1'b1;
    inEnd[s]   = last;
    mdlPush(s, w, last, doQ);
  endtask

  task automatic step();
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (discardCmd[s]) begin
        mdlRun[s] = mdlCom[s];
        asmL[s] = '0;
        asmN[s] = 0;
        expQ[s].delete();
      end else if (acceptCmd[s]) begin
        mdlCom[s] = mdlRun[s];
      end
    end
    if (rdReq && mdlCom[rdSel] != mdlRd[rdSel]) mdlRd[rdSel] = (mdlRd[rdSel] + 1) % SIZE;
    @(negedge clk);
    inValid = '0; inEnd = '0; acceptCmd = '0; discardCmd = '0; rdReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic readOne(int s);
    rdReq = 1'b1;
    rdSel = IW'(s);
    #1;
    check(rdAddr == AW'(s * SIZE + mdlRd[s]), "R10 read address", rdAddr, s * SIZE + mdlRd[s]);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    inData = '0; inValid = '0; inEnd = '0; acceptCmd = '0; discardCmd = '0;
    rdReq = 1'b0; rdSel = '0;
    for (int s = 0; s < NS; s++) begin
      asmL[s] = '0; asmN[s] = 0; mdlRun[s] = 0; mdlCom[s] = 0; mdlRd[s] = 0; lastLine[s] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(memWe == 1'b0, "R1 no write in reset", memWe, 0);
    check(overflow == '0, "R1 overflow clear", overflow, 0);
    check(rdAvail == '0, "R1 nothing available", rdAvail, 0);
    for (int s = 0; s < NS; s++)
      check(freeLines[s*RL +: RL] == 4'd15, "R1 free after reset", freeLines[s*RL +: RL], 15);
    rst = 1'b0;
    step();

    // R9 / R3: every lane closes a one-word event in the same cycle
    for (int s = 0; s < NS; s++) put(s, 16'hA000 + 16'(s), 1'b1);
    step();
    idle(16);
    check(wrOrder.size() == NS, "R9 write count", wrOrder.size(), NS);
    for (int k = 0; k < NS && k < wrOrder.size(); k++) begin
      check(wrOrder[k] == k, "R9 rotating grant order", wrOrder[k], k);
      check(wrCyc[k] == wrCyc[0] + k, "R9 one line per clock", wrCyc[k], wrCyc[0] + k);
    end
    check(lastLine[3] == {112'h0, 16'hA003}, "R3 zero padded flush", lastLine[3], {112'h0, 16'hA003});
    check(rdAvail == '0, "R6 nothing committed yet", rdAvail, 0);
    acceptCmd = '1;
    step();
    check(rdAvail == '1, "R6 accept makes data available", rdAvail, {NS{1'b1}});
    for (int s = 0; s < NS; s++) readOne(s);
    check(rdAvail == '0, "R10 reads consume lines", rdAvail, 0);

    // R2 / R3: gapped words on lane 5, dense words on lanes 0 and 1
    for (int k = 0; k < 8; k++) begin
      put(5, 16'h5100 + 16'(k), 1'b0);
      step();
      idle(k % 3);
    end
    for (int k = 0; k < 3; k++) begin
      put(5, 16'h5200 + 16'(k), k == 2);
      step();
      idle(1);
    end
    for (int k = 0; k < 8; k++) begin
      put(0, 16'h0C00 + 16'(k), 1'b0);
      put(1, 16'h1C00 + 16'(k), 1'b0);
      step();
    end
    idle(8);
    check(lastLine[5] == {80'h0, 16'h5202, 16'h5201, 16'h5200}, "R3 padded tail line",
          lastLine[5], {80'h0, 16'h5202, 16'h5201, 16'h5200});
    check(mdlRun[5] == 3, "R2 two lines written on gapped lane", mdlRun[5], 3);
    check(lastLine[1][127:112] == 16'h1C07, "R2 eighth word in top slot", lastLine[1][127:112], 16'h1C07);

    // R4 / R5 / R8: fill lane 7 until its region is full and wraps
    for (int n = 0; n < 15; n++) begin
      put(7, 16'h7000 + 16'(n), 1'b1);
      step();
      idle(2);
    end
    idle(4);
    check(mdlRun[7] == 0, "R4 running pointer wrapped", mdlRun[7], 0);
    check(freeLines[7*RL +: RL] == 4'd0, "R5 region full", freeLines[7*RL +: RL], 0);
    check(overflow[7] == 1'b0, "R8 no overflow before drop", overflow[7], 0);
    put(7, 16'h7FFF, 1'b1, 1'b0);
    step();
    idle(6);
    check(overflow[7] == 1'b1, "R8 overflow raised", overflow[7], 1);
    check((overflow & ~(12'h1 << 7)) == '0, "R8 other lanes clean", overflow, 12'h080);
    check(mdlRun[7] == 0, "R8 dropped line not written", mdlRun[7], 0);
    idle(3);
    check(overflow[7] == 1'b1, "R8 overflow sticky", overflow[7], 1);
    acceptCmd[7] = 1'b1;
    step();
    check(rdAvail[7] == 1'b1, "R6 full region committed", rdAvail[7], 1);
    for (int n = 0; n < 15; n++) readOne(7);
    check(rdAvail[7] == 1'b0, "R10 region drained", rdAvail[7], 0);
    check(freeLines[7*RL +: RL] == 4'd15, "R10 free restored", freeLines[7*RL +: RL], 15);

    // R7: discard with a written line, a partial line and a same-cycle word
    for (int k = 0; k < 8; k++) begin
      put(9, 16'h9000 + 16'(k), 1'b0);
      step();
    end
    for (int k = 0; k < 3; k++) begin
      put(9, 16'h9100 + 16'(k), 1'b0);
      step();
    end
    idle(4);
    check(mdlRun[9] == 2, "R7 line stored before discard", mdlRun[9], 2);
    put(9, 16'h9AAA, 1'b0);
    discardCmd[9] = 1'b1;
    step();
    idle(3);
    check(freeLines[9*RL +: RL] == 4'd15, "R7 running pointer rewound", freeLines[9*RL +: RL], 15);
    put(9, 16'h9BBB, 1'b1);
    step();
    idle(4);
    check(lastLine[9] == {112'h0, 16'h9BBB}, "R7 stale words dropped", lastLine[9], {112'h0, 16'h9BBB});
    check(mdlRun[9] == 2, "R7 rewritten at committed slot", mdlRun[9], 2);
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule